// File: doc/BRIEF.md
# Tagged 128-bit mailbox

This block is a one-way message slot between a producer and a consumer that share a register bus. A message is 128 bits wide and sits in four 32-bit payload words. A separate tag word marks whether a message is present. The producer fills the payload words first and then writes the tag with its top bit set, which publishes the message. The consumer reads the payload and then drains the slot by writing zero to every payload word and, last of all, to the tag.

The block drives two level conditions, one for "message waiting" and one for "slot free", which an interrupt aggregator elsewhere masks and combines. The block also watches the ordering protocol. It raises a sticky flag when a publish happens before every payload word has been written. It raises a second sticky flag when a non-zero payload write lands while a message is still waiting.

Top module: `tagged_mailbox`

## Requirements
- R1: After reset the tag and all four payload words read as zero, fullCond is 0, emptyCond is 1, and both error flags are 0.
- R2: A write to offset 0x48, 0x4C, 0x50 or 0x54 stores the word in payload word 0, 1, 2 or 3. The stored word appears on rdData when rdAddr selects that offset, from the cycle after the write and at any later time.
- R3: A write to the tag at offset 0x40 stores the word, and the tag reads back at 0x40. fullCond follows bit 31 of the stored tag: it rises on the cycle after a tag write with bit 31 set and falls on the cycle after a tag write with bit 31 clear. It does not change without a tag write.
- R4: emptyCond is always the complement of fullCond.
- R5: A non-zero write to a payload word while fullCond is 1 sets overwriteErr, and the word is still stored. A zero write while full (the consumer's drain) does not set it.
- R6: A tag write with bit 31 set, made before each of the four payload words has been written since the previous tag write, sets orderErr. The mailbox still becomes full. Any tag write starts a new tracking window.
- R7: A drain sequence (four zero payload writes, then a zero tag write) returns the mailbox to empty with every register reading zero.
- R8: Writes to offsets other than the five mapped ones change nothing. Reads of unmapped offsets, including the gap at 0x44, return zero.
- R9: overwriteErr and orderErr stay set until reset, through later drains and publishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Byte offset of the write |
| wrData | input | WORD_W | Write data |
| rdAddr | input | ADDR_W | Byte offset of the combinational read |
| rdData | output | WORD_W | Read data, zero for unmapped offsets |
| fullCond | output | 1 | Level: a message is waiting |
| emptyCond | output | 1 | Level: the slot is free |
| overwriteErr | output | 1 | Sticky: non-zero payload write while full |
| orderErr | output | 1 | Sticky: publish before all payload words were written |

## Verification
The assertions assume that wrEn is low or has a known value in every cycle after reset, and that wrAddr and wrData are valid whenever wrEn is high. The full-flag stability property also assumes that the tag changes only through the write port. The bench drives the write inputs only between the active edges and returns wrEn to zero after each single-cycle write. It drives rdAddr from a separate monitor process, so reads never disturb the write side. Misordered publishes and non-zero overwrites are produced on purpose, and each is followed by a reset before a run that must stay free of errors.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  // number of payload words in one message; fixes the strobe struct width
  localparam int unsigned TMB_WORDS = 4;

  // control-to-datapath write strobes
  typedef struct packed {
    logic [TMB_WORDS-1:0] dataWe;
    logic                 tagWe;
  } tmbStrobe_t;
endpackage

// File: rtl/tmb_ctrl.sv
module tmb_ctrl
  import tmb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned TAG_OFS  = 'h40,
  parameter int unsigned DATA_OFS = 'h48,
  parameter int unsigned STRIDE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              isFull,
  output tmbStrobe_t        strobe,
  output logic              overwriteErr,
  output logic              orderErr
);
  localparam int unsigned FLAG_BIT = WORD_W - 1;

  logic [TMB_WORDS-1:0] writtenMask;
  logic                 publishing;
  logic                 payloadHit;

  // address decode into strobes
  always_comb begin
    strobe.tagWe = wrEn && (wrAddr == ADDR_W'(TAG_OFS));
    for (int i = 0; i < TMB_WORDS; i++) begin
      strobe.dataWe[i] = wrEn && (wrAddr == ADDR_W'(DATA_OFS + i * STRIDE));
    end
  end

  assign publishing = strobe.tagWe && wrData[FLAG_BIT];
  assign payloadHit = |strobe.dataWe;

  // ordering tracker and sticky protocol flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      writtenMask  <= '0;
      overwriteErr <= 1'b0;
      orderErr     <= 1'b0;
    end else begin
      if (strobe.tagWe) begin
        writtenMask <= '0;
        if (publishing && (writtenMask != {TMB_WORDS{1'b1}})) begin
          orderErr <= 1'b1;
        end
      end else begin
        writtenMask <= writtenMask | strobe.dataWe;
      end
      if (payloadHit && isFull && (wrData != '0)) begin
        overwriteErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmb_datapath.sv
module tmb_datapath
  import tmb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned TAG_OFS  = 'h40,
  parameter int unsigned DATA_OFS = 'h48,
  parameter int unsigned STRIDE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmbStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              isFull
);
  localparam int unsigned FLAG_BIT = WORD_W - 1;

  logic [WORD_W-1:0] payload [TMB_WORDS];
  logic [WORD_W-1:0] tagReg;

  for (genvar g = 0; g < TMB_WORDS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        payload[g] <= '0;
      end else if (strobe.dataWe[g]) begin
        payload[g] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagReg <= '0;
    end else if (strobe.tagWe) begin
      tagReg <= wrData;
    end
  end

  assign isFull = tagReg[FLAG_BIT];

  // read mux, unmapped offsets return zero
  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(TAG_OFS)) begin
      rdData = tagReg;
    end
    for (int i = 0; i < TMB_WORDS; i++) begin
      if (rdAddr == ADDR_W'(DATA_OFS + i * STRIDE)) begin
        rdData = payload[i];
      end
    end
  end
endmodule

// File: rtl/tagged_mailbox.sv
module tagged_mailbox
  import tmb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned TAG_OFS  = 'h40,
  parameter int unsigned DATA_OFS = 'h48,
  parameter int unsigned STRIDE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              fullCond,
  output logic              emptyCond,
  output logic              overwriteErr,
  output logic              orderErr
);
  tmbStrobe_t strobe;
  logic       isFull;

  tmb_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .TAG_OFS(TAG_OFS),
    .DATA_OFS(DATA_OFS), .STRIDE(STRIDE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .isFull(isFull), .strobe(strobe),
    .overwriteErr(overwriteErr), .orderErr(orderErr)
  );

  tmb_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .TAG_OFS(TAG_OFS),
    .DATA_OFS(DATA_OFS), .STRIDE(STRIDE)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .isFull(isFull)
  );

  assign fullCond  = isFull;
  assign emptyCond = ~isFull;
endmodule

// File: rtl/tagged_mailbox_chk.sv
module tagged_mailbox_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned TAG_OFS  = 'h40,
  parameter int unsigned DATA_OFS = 'h48,
  parameter int unsigned STRIDE   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [WORD_W-1:0] wrData,
  input logic              fullCond,
  input logic              overwriteErr,
  input logic              orderErr
);
  logic tagWr;
  logic dataWr;
  assign tagWr  = wrEn && (wrAddr == ADDR_W'(TAG_OFS));
  assign dataWr = wrEn && (wrAddr >= ADDR_W'(DATA_OFS))
                       && (wrAddr <= ADDR_W'(DATA_OFS + 3 * STRIDE))
                       && (wrAddr[1:0] == 2'b00);

  // R3: a publish shows full on the next cycle
  a_r3_full_rise: assert property (@(posedge clk) disable iff (!rstN)
    tagWr && wrData[WORD_W-1] |=> fullCond);

  // R3: a tag write without the flag bit empties the slot
  a_r3_full_fall: assert property (@(posedge clk) disable iff (!rstN)
    tagWr && !wrData[WORD_W-1] |=> !fullCond);

  // R3: full only changes through a tag write
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tagWr |=> $stable(fullCond));

  // R5: non-zero payload write while full raises the overwrite flag
  a_r5_overwrite_set: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && fullCond && (wrData != '0) |=> overwriteErr);

  // R9: both protocol flags are sticky
  a_r9_overwrite_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overwriteErr |=> overwriteErr);
  a_r9_order_sticky: assert property (@(posedge clk) disable iff (!rstN)
    orderErr |=> orderErr);
endmodule

bind tagged_mailbox tagged_mailbox_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .TAG_OFS(TAG_OFS),
  .DATA_OFS(DATA_OFS), .STRIDE(STRIDE)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .fullCond(fullCond), .overwriteErr(overwriteErr), .orderErr(orderErr)
);

// File: tb/tb_tagged_mailbox.sv
`timescale 1ns/1ps
module tb_tagged_mailbox;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;
  localparam logic [7:0] TAG = 8'h40;
  localparam logic [7:0] D0 = 8'h48, D1 = 8'h4C, D2 = 8'h50, D3 = 8'h54;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [WORD_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [WORD_W-1:0] rdData;
  logic fullCond, emptyCond, overwriteErr, orderErr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tagged_mailbox dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .fullCond(fullCond),
    .emptyCond(emptyCond), .overwriteErr(overwriteErr), .orderErr(orderErr)
  );

  // expected item: read offset, word, flags {full, empty, ovw, order}
  typedef struct {
    logic [7:0]  addr;
    logic [31:0] val;
    logic [3:0]  flags;
    string       req;
  } item_t;

  item_t sbq[$];

  // monitor: pops an item, selects the read offset, compares
  initial begin
    forever begin
      wait (sbq.size() > 0);
      begin
        item_t it;
        logic [3:0] got;
        it = sbq.pop_front();
        rdAddr = it.addr;
        #1;
        got = {fullCond, emptyCond, overwriteErr, orderErr};
        checks++;
        if (rdData !== it.val || got !== it.flags) begin
          errors++;
          $display("FAIL %s addr=%h data actual=%h expected=%h flags actual=%b expected=%b",
                   it.req, it.addr, rdData, it.val, got, it.flags);
        end
      end
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] v,
                           input logic [3:0] f, input string req);
    item_t it;
    it.addr = a; it.val = v; it.flags = f; it.req = req;
    sbq.push_back(it);
    wait (sbq.size() == 0);
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // flag encodings {full, empty, ovw, order}
  localparam logic [3:0] F_EMPTY = 4'b0100;
  localparam logic [3:0] F_FULL  = 4'b1000;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    expect_rd(TAG, 32'h0, F_EMPTY, "R1");
    expect_rd(D0, 32'h0, F_EMPTY, "R1");
    expect_rd(D3, 32'h0, F_EMPTY, "R1");

    // R2 payload write and readback, still empty
    wr(D0, 32'h1111_0001); wr(D1, 32'hA5A5_5A5A);
    wr(D2, 32'h0000_FFFF); wr(D3, 32'hDEAD_BEEF);
    expect_rd(D0, 32'h1111_0001, F_EMPTY, "R2");
    expect_rd(D1, 32'hA5A5_5A5A, F_EMPTY, "R2");
    expect_rd(D2, 32'h0000_FFFF, F_EMPTY, "R2");
    expect_rd(D3, 32'hDEAD_BEEF, F_EMPTY, "R2");

    // R3/R4 publish
    wr(TAG, 32'h8000_00A5);
    expect_rd(TAG, 32'h8000_00A5, F_FULL, "R3");
    expect_rd(D1, 32'hA5A5_5A5A, F_FULL, "R4");

    // R5/R7 drain: zero writes while full do not flag overwrite
    wr(D0, 0); wr(D1, 0); wr(D2, 0); wr(D3, 0);
    expect_rd(D2, 32'h0, F_FULL, "R5");
    wr(TAG, 0);
    expect_rd(TAG, 32'h0, F_EMPTY, "R7");
    expect_rd(D3, 32'h0, F_EMPTY, "R7");

    // R8 unmapped write and read
    wr(8'h44, 32'h1234_5678);
    wr(8'h58, 32'h8765_4321);
    expect_rd(8'h44, 32'h0, F_EMPTY, "R8");
    expect_rd(8'h58, 32'h0, F_EMPTY, "R8");
    expect_rd(TAG, 32'h0, F_EMPTY, "R8");

    // R5 overwrite while full
    wr(D0, 1); wr(D1, 2); wr(D2, 3); wr(D3, 4);
    wr(TAG, 32'h8000_0000);
    expect_rd(D1, 32'h2, F_FULL, "R3");
    wr(D1, 32'h0000_0099);
    expect_rd(D1, 32'h0000_0099, 4'b1010, "R5");
    // R9 flag survives a drain
    wr(D0, 0); wr(D1, 0); wr(D2, 0); wr(D3, 0); wr(TAG, 0);
    expect_rd(TAG, 32'h0, 4'b0110, "R9");

    // R1 reset clears the flags
    do_reset();
    expect_rd(D0, 32'h0, F_EMPTY, "R1");

    // R6 publish after only two payload words
    wr(D0, 32'h55); wr(D2, 32'h66);
    wr(TAG, 32'h8000_0001);
    expect_rd(TAG, 32'h8000_0001, 4'b1001, "R6");
    // R3 tag write with flag clear empties the slot
    wr(TAG, 32'h0000_0007);
    expect_rd(TAG, 32'h0000_0007, 4'b0101, "R3");
    // R9 order flag stays after a proper publish
    wr(D0, 1); wr(D1, 1); wr(D2, 1); wr(D3, 1);
    wr(TAG, 32'h8000_0000);
    expect_rd(TAG, 32'h8000_0000, 4'b1001, "R9");

    // R6 complete ordering after reset raises no flag
    do_reset();
    wr(D3, 9); wr(D2, 8); wr(D1, 7); wr(D0, 6);
    wr(TAG, 32'hFFFF_FFFF);
    expect_rd(D0, 32'h6, F_FULL, "R6");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule